// File: doc/BRIEF.md
# Channel-Tagged Debug Mailbox

The block is a two-way mailbox between a processor core and an external debug probe. Each direction has its own FIFO. Every entry in either FIFO holds a 32-bit data word and a 4-bit channel tag. The probe side uses the tag to tell apart streams that share one physical link, such as console text, trace words and command replies.

On the core side there is a simple word-addressed register port.

- **Status:** word 0 is a read-only status word.
- **Receive data:** word 1 returns the head of the probe-to-core FIFO and consumes it.
- **Transmit window:** words 16 to 31 form a window of sixteen write-only aliases into the core-to-probe FIFO. The low four address bits of a write become the channel tag stored with the word, so no extra register write is needed to choose a channel.

On the probe side there are two valid/ready ports. One pushes tagged words into the receive FIFO. The other drains tagged words from the transmit FIFO.

Reads are registered. Read data and its valid strobe appear on the cycle after the request.

Top module: `dbg_mailbox`

## Requirements
- R1: After synchronous reset both FIFOs are empty, the status word reads 0x0000000A, `probe_tx_valid` is 0 and `probe_rx_ready` is 1.
- R2: A write to word address 16+c (c in 0..15) pushes the write data together with tag c into the transmit FIFO. The probe sees that word on `probe_tx_data` and the tag c on `probe_tx_chan`.
- R3: The transmit FIFO holds 8 entries. Once it holds 8, status bit 0 (transmit full) is 1 and bit 1 (transmit empty) is 0. A transmit write made while full is dropped, so exactly the 8 earlier words drain out.
- R4: The receive FIFO holds 8 entries and accepts a probe push only while `probe_rx_ready` is 1. That signal is 0 while the FIFO is full, and a push offered then leaves the contents unchanged.
- R5: A read of word 1 returns the receive head data on `bus_rdata` in the following cycle. The same clock edge removes that entry.
- R6: A read of word 1 while the receive FIFO is empty returns 0 and leaves both pointers unchanged. A later push is read back intact.
- R7: The status flags are: bit 0 transmit full, bit 1 transmit empty, bit 2 receive full, bit 3 receive empty. A partly filled FIFO has both of its flags at 0.
- R8: Status bits 7:4 carry the channel tag of the receive head entry, and read 0 while the receive FIFO is empty. Status bits 31:8 always read 0; this includes the unimplemented fill-count fields in bits 31:16.
- R9: Both FIFOs keep first-in first-out order. A receive push and a receive read in the same cycle leave the entry count unchanged.
- R10: `bus_rvalid` is 1 exactly in the cycle after each `bus_rd`. A read of an unmapped word returns 0. A write to any word below 16 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Core word address |
| bus_wr | input | 1 | Core write strobe |
| bus_wdata | input | 32 | Core write data |
| bus_rd | input | 1 | Core read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| probe_rx_valid | input | 1 | Probe offers a word to the receive FIFO |
| probe_rx_ready | output | 1 | Receive FIFO can accept a word |
| probe_rx_data | input | 32 | Word pushed by the probe |
| probe_rx_chan | input | 4 | Channel tag pushed by the probe |
| probe_tx_valid | output | 1 | Transmit FIFO has a word for the probe |
| probe_tx_ready | input | 1 | Probe takes the transmit head |
| probe_tx_data | output | 32 | Transmit head data |
| probe_tx_chan | output | 4 | Transmit head channel tag |

## Verification
The assertions assume two things about the core. First, it does not overlap a read of the receive word with a probe push that expects the entry count to grow past eight. Second, it holds `bus_addr` steady during a read strobe. Under those assumptions, the head of the transmit FIFO stays stable while the probe is not taking it, and a full receive FIFO stays full until a receive read is made. The stimulus drives one bus transaction per strobe, changes inputs only between clock edges, and offers probe pushes against a full FIFO only as deliberate overflow tests whose effect is then checked by draining.

// File: rtl/dbgmb_pkg.sv
package dbgmb_pkg;
  localparam int DATA_W = 32;
  localparam int CHAN_W = 4;

  // Fixed word addresses on the core port
  localparam int STAT_WORD = 0;
  localparam int RXD_WORD  = 1;

  // Status bit positions (decoded by software)
  localparam int ST_TXF = 0;
  localparam int ST_TXE = 1;
  localparam int ST_RXF = 2;
  localparam int ST_RXE = 3;
  localparam int ST_CH_LO = 4;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [CHAN_W-1:0] chan;
  } mb_entry_t;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_STAT = 2'd1,
    RSEL_RXD  = 2'd2
  } rsel_e;
endpackage

// File: rtl/dbgmb_fifo.sv
module dbgmb_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             empty_q, full_q;
  logic             do_push, do_pop;

  assign do_push = push && !full_q;
  assign do_pop  = pop && !empty_q;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // Storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_comb begin
    cnt_nxt = cnt;
    unique case ({do_push, do_pop})
      2'b10:   cnt_nxt = cnt + 1'b1;
      2'b01:   cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      cnt     <= cnt_nxt;
      empty_q <= (cnt_nxt == '0);
      full_q  <= (cnt_nxt == CNT_FULL);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = empty_q;
  assign full  = full_q;
endmodule

// File: rtl/dbgmb_decode.sv
module dbgmb_decode
  import dbgmb_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              tx_push,
  output logic [CHAN_W-1:0] tx_chan,
  output logic              rx_pop,
  output rsel_e             rsel
);
  localparam int HI_W = ADDR_W - CHAN_W;

  logic tx_hit;
  assign tx_hit  = (addr[ADDR_W-1:CHAN_W] == HI_W'(1));
  assign tx_push = wr && tx_hit;
  assign tx_chan = addr[CHAN_W-1:0];

  always_comb begin
    rsel = RSEL_NONE;
    if (addr == ADDR_W'(STAT_WORD))     rsel = RSEL_STAT;
    else if (addr == ADDR_W'(RXD_WORD)) rsel = RSEL_RXD;
  end

  assign rx_pop = rd && (rsel == RSEL_RXD);
endmodule

// File: rtl/dbgmb_rdport.sv
module dbgmb_rdport
  import dbgmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  rsel_e             rsel,
  input  logic [DATA_W-1:0] stat_word,
  input  logic [DATA_W-1:0] rx_head_data,
  input  logic              rx_empty,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] rdata_nxt;

  always_comb begin
    unique case (rsel)
      RSEL_STAT: rdata_nxt = stat_word;
      RSEL_RXD:  rdata_nxt = rx_empty ? '0 : rx_head_data;
      default:   rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? rdata_nxt : '0;
    end
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbgmb_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              probe_rx_valid,
  output logic              probe_rx_ready,
  input  logic [31:0]       probe_rx_data,
  input  logic [3:0]        probe_rx_chan,
  output logic              probe_tx_valid,
  input  logic              probe_tx_ready,
  output logic [31:0]       probe_tx_data,
  output logic [3:0]        probe_tx_chan
);
  localparam int ENT_W = $bits(mb_entry_t);

  logic              tx_push, rx_pop;
  logic [CHAN_W-1:0] tx_chan;
  rsel_e             rsel;
  mb_entry_t         tx_in, tx_head, rx_in, rx_head;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [DATA_W-1:0] stat_word;

  dbgmb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .tx_push (tx_push),
    .tx_chan (tx_chan),
    .rx_pop  (rx_pop),
    .rsel    (rsel)
  );

  assign tx_in = '{data: bus_wdata, chan: tx_chan};
  assign rx_in = '{data: probe_rx_data, chan: probe_rx_chan};

  dbgmb_fifo #(.DEPTH(TX_DEPTH), .WIDTH(ENT_W)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .push      (tx_push),
    .push_data (tx_in),
    .pop       (probe_tx_ready),
    .head      (tx_head),
    .empty     (tx_empty),
    .full      (tx_full)
  );

  dbgmb_fifo #(.DEPTH(RX_DEPTH), .WIDTH(ENT_W)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .push      (probe_rx_valid),
    .push_data (rx_in),
    .pop       (rx_pop),
    .head      (rx_head),
    .empty     (rx_empty),
    .full      (rx_full)
  );

  always_comb begin
    stat_word = '0;
    stat_word[ST_TXF] = tx_full;
    stat_word[ST_TXE] = tx_empty;
    stat_word[ST_RXF] = rx_full;
    stat_word[ST_RXE] = rx_empty;
    stat_word[ST_CH_LO +: CHAN_W] = rx_empty ? '0 : rx_head.chan;
  end

  dbgmb_rdport u_rd (
    .clk          (clk),
    .rst          (rst),
    .rd           (bus_rd),
    .rsel         (rsel),
    .stat_word    (stat_word),
    .rx_head_data (rx_head.data),
    .rx_empty     (rx_empty),
    .rdata        (bus_rdata),
    .rvalid       (bus_rvalid)
  );

  assign probe_rx_ready = !rx_full;
  assign probe_tx_valid = !tx_empty;
  assign probe_tx_data  = tx_head.data;
  assign probe_tx_chan  = tx_head.chan;
endmodule

// File: rtl/dbgmb_checker.sv
module dbgmb_checker
  import dbgmb_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              probe_rx_ready,
  input logic              probe_tx_valid,
  input logic              probe_tx_ready,
  input logic [31:0]       probe_tx_data,
  input logic [3:0]        probe_tx_chan,
  input logic              rx_empty
);
  assert_rvalid_after_rd_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  assert_no_spurious_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);

  assert_tx_head_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (probe_tx_valid && !probe_tx_ready) |=>
      (probe_tx_valid && $stable(probe_tx_data) && $stable(probe_tx_chan)));

  assert_rx_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!probe_rx_ready && !(bus_rd && bus_addr == ADDR_W'(RXD_WORD))) |=> !probe_rx_ready);

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(RXD_WORD) && rx_empty) |=> (bus_rdata == 32'h0));

  assert_status_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(STAT_WORD)) |=> (bus_rdata[31:8] == 24'h0));
endmodule

bind dbg_mailbox dbgmb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_addr       (bus_addr),
  .bus_rd         (bus_rd),
  .bus_rdata      (bus_rdata),
  .bus_rvalid     (bus_rvalid),
  .probe_rx_ready (probe_rx_ready),
  .probe_tx_valid (probe_tx_valid),
  .probe_tx_ready (probe_tx_ready),
  .probe_tx_data  (probe_tx_data),
  .probe_tx_chan  (probe_tx_chan),
  .rx_empty       (rx_empty)
);

// File: tb/tb_dbg_mailbox.sv
module tb_dbg_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        probe_rx_valid = 1'b0;
  logic        probe_rx_ready;
  logic [31:0] probe_rx_data = '0;
  logic [3:0]  probe_rx_chan = '0;
  logic        probe_tx_valid;
  logic        probe_tx_ready = 1'b0;
  logic [31:0] probe_tx_data;
  logic [3:0]  probe_tx_chan;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbg_mailbox dut (.*);

  function automatic logic [31:0] tx_word(int c, int r);
    return 32'h1000_0000 + 32'(r) * 32'h0001_0000 + 32'(c) * 32'h0000_0111;
  endfunction
  function automatic logic [31:0] rx_word(int i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0000_0101;
  endfunction
  function automatic logic [3:0] rx_tag(int i);
    return 4'((i * 5 + 3) & 15);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic probe_push(logic [31:0] d, logic [3:0] c);
    @(negedge clk);
    probe_rx_valid = 1'b1; probe_rx_data = d; probe_rx_chan = c;
    @(negedge clk);
    probe_rx_valid = 1'b0;
  endtask

  task automatic probe_take(string req, logic [31:0] d, logic [3:0] c);
    @(negedge clk);
    chk({req, " tx valid"}, {31'b0, probe_tx_valid}, 32'd1);
    chk({req, " tx data"}, probe_tx_data, d);
    chk({req, " tx chan"}, {28'b0, probe_tx_chan}, {28'b0, c});
    probe_tx_ready = 1'b1;
    @(negedge clk);
    probe_tx_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk("R1 tx valid", {31'b0, probe_tx_valid}, 32'd0);
    chk("R1 rx ready", {31'b0, probe_rx_ready}, 32'd1);
    bus_read(5'd0, rv); chk("R1 status", rv, 32'h0000_000A);

    // R10 unmapped accesses
    bus_write(5'd5, 32'hFFFF_FFFF);
    bus_write(5'd0, 32'hFFFF_FFFF);
    bus_read(5'd0, rv); chk("R10 low write ignored", rv, 32'h0000_000A);
    bus_read(5'd7, rv); chk("R10 unmapped read", rv, 32'h0);
    @(negedge clk);
    chk("R10 rvalid drops", {31'b0, bus_rvalid}, 32'd0);
    chk("R10 no tx entry", {31'b0, probe_tx_valid}, 32'd0);

    // R2/R3/R7/R9 transmit sweep over all 16 channels in two rounds
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 8; k++) begin
        bus_write(5'(16 + r * 8 + k), tx_word(r * 8 + k, r));
        if (k == 0) begin
          bus_read(5'd0, rv); chk("R7 tx partial flags", {30'b0, rv[1:0]}, 32'd0);
        end
      end
      bus_read(5'd0, rv); chk("R3 tx full flags", {30'b0, rv[1:0]}, 32'd1);
      bus_write(5'd16, 32'hDEAD_BEEF);
      for (int k = 0; k < 8; k++)
        probe_take("R2 R9", tx_word(r * 8 + k, r), 4'(r * 8 + k));
      @(negedge clk);
      chk("R3 dropped write", {31'b0, probe_tx_valid}, 32'd0);
      bus_read(5'd0, rv); chk("R3 tx empty flags", {30'b0, rv[1:0]}, 32'd2);
    end

    // R4/R7/R8 receive fill
    for (int i = 0; i < 8; i++) begin
      probe_push(rx_word(i), rx_tag(i));
      if (i == 0) begin
        bus_read(5'd0, rv);
        chk("R7 rx partial flags", {30'b0, rv[3:2]}, 32'd0);
        chk("R8 head chan", {28'b0, rv[7:4]}, {28'b0, rx_tag(0)});
      end
    end
    @(negedge clk);
    chk("R4 rx ready low", {31'b0, probe_rx_ready}, 32'd0);
    bus_read(5'd0, rv); chk("R4 rx full flags", {30'b0, rv[3:2]}, 32'd1);
    probe_push(32'hBAD0_BAD0, 4'hF);

    // R5/R8 drain
    for (int i = 0; i < 8; i++) begin
      bus_read(5'd0, rv);
      chk("R8 head chan", {28'b0, rv[7:4]}, {28'b0, rx_tag(i)});
      chk("R8 upper zero", {8'b0, rv[31:8]}, 32'h0);
      bus_read(5'd1, rv); chk("R5 rx data", rv, rx_word(i));
    end
    bus_read(5'd0, rv); chk("R4 overflow ignored", rv, 32'h0000_000A);

    // R6 empty read
    bus_read(5'd1, rv); chk("R6 empty read", rv, 32'h0);
    bus_read(5'd0, rv); chk("R6 status after empty read", rv, 32'h0000_000A);
    probe_push(rx_word(20), rx_tag(20));
    bus_read(5'd1, rv); chk("R6 intact after empty read", rv, rx_word(20));

    // R9 push and read in the same cycle
    probe_push(rx_word(0), rx_tag(0));
    probe_push(rx_word(1), rx_tag(1));
    @(negedge clk);
    bus_addr = 5'd1; bus_rd = 1'b1;
    probe_rx_valid = 1'b1; probe_rx_data = rx_word(2); probe_rx_chan = rx_tag(2);
    @(negedge clk);
    bus_rd = 1'b0; probe_rx_valid = 1'b0;
    chk("R9 concurrent read", bus_rdata, rx_word(0));
    bus_read(5'd0, rv);
    chk("R9 count kept", {30'b0, rv[3:2]}, 32'd0);
    chk("R9 head chan", {28'b0, rv[7:4]}, {28'b0, rx_tag(1)});
    bus_read(5'd1, rv); chk("R9 order 1", rv, rx_word(1));
    bus_read(5'd1, rv); chk("R9 order 2", rv, rx_word(2));
    bus_read(5'd0, rv); chk("R9 empty", rv, 32'h0000_000A);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule